// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block serves one bus-master DMA channel. Software prepares, in memory, a table of 8-byte scatter-gather descriptors, each naming one physical memory region and its byte count. After a start pulse the walker holds the table base and the transfer direction. It then takes transfer requests from the drive side. Each request is a byte count. For each one the walker reads descriptors through a simple 64-bit memory read port. It issues address/length burst requests to a downstream data mover until the requested bytes are covered or the table runs out.

A region that is only partly used by one request keeps its remaining bytes for the next request. The walk ends when an empty region is reached and either the final descriptor has been consumed or the descriptor pointer has moved a full table window (one page by default) past the base. This fail-safe bounds a walk even when a table has no end marker. A cancel pulse drops the walker back to idle at once and withdraws any burst request it is presenting.

Top module: `prd_walker`

## Requirements
- R1: After reset the walker is idle: `want_ready`, `mem_rd_req`, `brst_valid`, `done`, `eot` and `underrun` are all low.
- R2: A `start` pulse (with `cancel` low) loads `tbl_base` and `dir_wr`, and clears the current region length, region address and last flag. `want_ready` is high on the next cycle. The first descriptor read of the walk is at `tbl_base`.
- R3: A descriptor read returns 64 bits with byte 0 in bits 7:0. Bits 31:0 are the region address and bits 63:32 the size word. The region byte count is the size word ANDed with 0xFFFE, so size bits 0 and 30:16 have no effect.
- R4: A masked byte count of zero means a region of 65536 bytes.
- R5: A descriptor is read only when the current region has no bytes left. Each read advances the descriptor pointer by 8, so reads within a walk go to consecutive 8-byte addresses.
- R6: Each burst request carries the region's current address and a length equal to the smaller of the bytes still wanted and the bytes left in the region. After each burst the region address rises and the region count falls by that length. `brst_write` equals the `dir_wr` value captured at start.
- R7: When a request is covered with bytes left in the region, the next request continues from the next unused region address without reading a new descriptor.
- R8: When the region is empty and the descriptor whose size-word bit 31 (data bit 63) is set has been consumed, no further descriptor is read, `eot` pulses for one cycle and the walker returns to idle.
- R9: When the region is empty and the pointer has advanced `LIM_BYTES` or more past the base, the walk ends in the same way as in R8, even with no end marker.
- R10: `done` pulses for one cycle when a request is fully covered. `underrun` pulses together with `eot` when the table ends before the request is covered. `done` and `underrun` never pulse together.
- R11: A `cancel` pulse makes `brst_valid`, `mem_rd_req` and `want_ready` low on the next cycle. No burst request is issued afterwards until a new start.
- R12: While `brst_valid` is high and `brst_ready` low, `brst_valid`, `brst_addr` and `brst_len` stay unchanged.
- R13: A request with `want_len` of zero is ignored: no descriptor read, no burst and no `done`, and `want_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new table walk |
| cancel | input | 1 | Abort the walk, return to idle |
| tbl_base | input | AW | Descriptor table base address |
| dir_wr | input | 1 | Transfer direction captured at start |
| want_ready | output | 1 | Walker can accept a transfer request |
| want_valid | input | 1 | Transfer request strobe |
| want_len | input | WLW | Requested byte count |
| mem_rd_req | output | 1 | Descriptor read request, held until data returns |
| mem_rd_addr | output | AW | Descriptor read address |
| mem_rd_valid | input | 1 | Descriptor read data valid |
| mem_rd_data | input | 64 | Descriptor read data, little-endian |
| brst_valid | output | 1 | Burst request valid |
| brst_ready | input | 1 | Data mover accepts the burst |
| brst_addr | output | AW | Burst start address |
| brst_len | output | 17 | Burst byte count (1 to 65536) |
| brst_write | output | 1 | Burst direction |
| done | output | 1 | Request covered (one-cycle pulse) |
| eot | output | 1 | Table ended, walk over (one-cycle pulse) |
| underrun | output | 1 | Table ended short of the request (one-cycle pulse) |

## Verification
The bench builds the walker with `LIM_BYTES` = 64, so the window holds eight descriptors and the fail-safe stop is reached by a table of nine entries without an end marker. With `WLW` = 20, one request can exceed a 65536-byte region, so the zero-length encoding is used up in a single request and its leftover is carried into the next. Tables of every length from one to eight entries, each with its end marker, plus the unmarked table, are walked in both directions. Backpressure on the burst port is applied in half of them.

// File: rtl/prd_pkg.sv
// Package: shared constants and state encoding for the descriptor walker.
// Assumes a 32-bit size word whose low 16 bits carry the byte count.
package prd_pkg;
    localparam int SIZE_FIELD_W = 16;
    localparam int REG_LEN_W    = SIZE_FIELD_W + 1;   // holds 65536
    localparam int DESC_BYTES   = 8;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READY,
        WS_SCAN,
        WS_FETCH,
        WS_MOVE
    } walk_st_t;
endpackage

// File: rtl/prd_decode.sv
// Module: prd_decode
// Splits one little-endian 64-bit descriptor into region address, even
// byte count (zero count means 65536) and end-of-table flag.
// Assumes AW <= 32.
module prd_decode #(
    parameter int AW = 32
) (
    input  logic [63:0]                    word,
    output logic [AW-1:0]                  reg_addr,
    output logic [prd_pkg::REG_LEN_W-1:0]  reg_len,
    output logic                           reg_last
);
    localparam int SW = prd_pkg::SIZE_FIELD_W;

    logic [SW-2:0] cnt_hi;
    logic          unused_bits;

    // Decode the address word, the masked count and the end marker.
    always_comb begin
        cnt_hi   = word[32+SW-1:33];
        reg_addr = word[AW-1:0];
        reg_last = word[63];
        if (cnt_hi == '0) begin
            reg_len = {1'b1, {SW{1'b0}}};
        end else begin
            reg_len = {1'b0, cnt_hi, 1'b0};
        end
    end

    assign unused_bits = ^{word[62:32+SW], word[32]};
endmodule

// File: rtl/prd_chunk.sv
// Module: prd_chunk
// Picks the next burst size: the smaller of the bytes still wanted and the
// bytes left in the region. Also flags when the request fits in the region.
module prd_chunk #(
    parameter int WLW = 24,
    parameter int RLW = 17
) (
    input  logic [WLW-1:0] want_left,
    input  logic [RLW-1:0] reg_left,
    output logic [RLW-1:0] chunk,
    output logic           want_fits
);
    localparam int CW = (WLW > RLW) ? WLW : RLW;

    logic [CW-1:0] w_ext;
    logic [CW-1:0] r_ext;
    logic [CW-1:0] pick;

    // Compare both counts at a common width and keep the smaller.
    always_comb begin
        w_ext     = CW'(want_left);
        r_ext     = CW'(reg_left);
        want_fits = (w_ext <= r_ext);
        pick      = want_fits ? w_ext : r_ext;
        chunk     = pick[RLW-1:0];
    end
endmodule

// File: rtl/prd_walker.sv
// Module: prd_walker (top)
// Walks a scatter-gather descriptor table for one DMA channel. It reads
// descriptors when the current region is empty and issues bursts sized to
// the smaller of the outstanding request and the region remainder. It stops
// on the end marker or after LIM_BYTES of table.
// Assumes LIM_BYTES is a multiple of 8 and AW <= 32.
module prd_walker #(
    parameter int AW        = 32,
    parameter int WLW       = 24,
    parameter int LIM_BYTES = 4096
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           cancel,
    input  logic [AW-1:0]                  tbl_base,
    input  logic                           dir_wr,
    output logic                           want_ready,
    input  logic                           want_valid,
    input  logic [WLW-1:0]                 want_len,
    output logic                           mem_rd_req,
    output logic [AW-1:0]                  mem_rd_addr,
    input  logic                           mem_rd_valid,
    input  logic [63:0]                    mem_rd_data,
    output logic                           brst_valid,
    input  logic                           brst_ready,
    output logic [AW-1:0]                  brst_addr,
    output logic [prd_pkg::REG_LEN_W-1:0]  brst_len,
    output logic                           brst_write,
    output logic                           done,
    output logic                           eot,
    output logic                           underrun
);
    import prd_pkg::*;

    localparam int RLW = REG_LEN_W;
    localparam int OW  = $clog2(LIM_BYTES) + 1;

    walk_st_t        st_q;
    logic [AW-1:0]   base_q;
    logic [OW-1:0]   ofs_q;
    logic [AW-1:0]   raddr_q;
    logic [RLW-1:0]  rem_q;
    logic            last_q;
    logic [WLW-1:0]  want_q;
    logic            wr_q;

    logic [AW-1:0]   dec_addr;
    logic [RLW-1:0]  dec_len;
    logic            dec_last;
    logic [RLW-1:0]  chunk;
    logic            fits;
    logic            tbl_end;

    prd_decode #(.AW(AW)) u_dec (
        .word     (mem_rd_data),
        .reg_addr (dec_addr),
        .reg_len  (dec_len),
        .reg_last (dec_last)
    );

    prd_chunk #(.WLW(WLW), .RLW(RLW)) u_chunk (
        .want_left (want_q),
        .reg_left  (rem_q),
        .chunk     (chunk),
        .want_fits (fits)
    );

    // Table exhausted: end marker consumed or window fail-safe reached.
    assign tbl_end = last_q || (ofs_q >= OW'(LIM_BYTES));

    // Port outputs derived from the walk state.
    assign want_ready  = (st_q == WS_READY);
    assign mem_rd_req  = (st_q == WS_FETCH);
    assign mem_rd_addr = base_q + AW'(ofs_q);
    assign brst_valid  = (st_q == WS_MOVE);
    assign brst_addr   = raddr_q;
    assign brst_len    = chunk;
    assign brst_write  = wr_q;

    // Walk sequencer: start/cancel, descriptor fetch, burst issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WS_IDLE;
            base_q   <= '0;
            ofs_q    <= '0;
            raddr_q  <= '0;
            rem_q    <= '0;
            last_q   <= 1'b0;
            want_q   <= '0;
            wr_q     <= 1'b0;
            done     <= 1'b0;
            eot      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            done     <= 1'b0;
            eot      <= 1'b0;
            underrun <= 1'b0;
            if (cancel) begin
                st_q <= WS_IDLE;
            end else if (start) begin
                base_q  <= tbl_base;
                ofs_q   <= '0;
                raddr_q <= '0;
                rem_q   <= '0;
                last_q  <= 1'b0;
                want_q  <= '0;
                wr_q    <= dir_wr;
                st_q    <= WS_READY;
            end else begin
                case (st_q)
                    WS_READY: begin
                        if (want_valid && (want_len != '0)) begin
                            want_q <= want_len;
                            st_q   <= WS_SCAN;
                        end
                    end
                    WS_SCAN: begin
                        if (rem_q != '0) begin
                            st_q <= WS_MOVE;
                        end else if (tbl_end) begin
                            eot      <= 1'b1;
                            underrun <= 1'b1;
                            st_q     <= WS_IDLE;
                        end else begin
                            st_q <= WS_FETCH;
                        end
                    end
                    WS_FETCH: begin
                        if (mem_rd_valid) begin
                            raddr_q <= dec_addr;
                            rem_q   <= dec_len;
                            last_q  <= dec_last;
                            ofs_q   <= ofs_q + OW'(DESC_BYTES);
                            st_q    <= WS_SCAN;
                        end
                    end
                    WS_MOVE: begin
                        if (brst_ready) begin
                            raddr_q <= raddr_q + AW'(chunk);
                            rem_q   <= rem_q - chunk;
                            want_q  <= want_q - WLW'(chunk);
                            if (fits) begin
                                done <= 1'b1;
                                if ((rem_q == chunk) && tbl_end) begin
                                    eot  <= 1'b1;
                                    st_q <= WS_IDLE;
                                end else begin
                                    st_q <= WS_READY;
                                end
                            end else begin
                                st_q <= WS_SCAN;
                            end
                        end
                    end
                    default: st_q <= WS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/prd_walker_chk.sv
// Module: prd_walker_chk
// Port-level protocol checks for prd_walker, attached by bind below.
// Tracks the table base itself from the start pulse.
module prd_walker_chk #(
    parameter int AW        = 32,
    parameter int LIM_BYTES = 4096
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start,
    input logic                           cancel,
    input logic [AW-1:0]                  tbl_base,
    input logic                           want_ready,
    input logic                           mem_rd_req,
    input logic [AW-1:0]                  mem_rd_addr,
    input logic                           brst_valid,
    input logic                           brst_ready,
    input logic [AW-1:0]                  brst_addr,
    input logic [prd_pkg::REG_LEN_W-1:0]  brst_len,
    input logic                           done,
    input logic                           eot,
    input logic                           underrun
);
    logic [AW-1:0] base_c;

    // Remember the base seen on the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_c <= '0;
        end else if (start && !cancel) begin
            base_c <= tbl_base;
        end
    end

    AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cancel) |=> want_ready); // R2
    AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        brst_valid |-> ((brst_len != '0) && (brst_len <= 17'h10000))); // R6
    AST_FETCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> ((mem_rd_addr - base_c) < AW'(LIM_BYTES))); // R9
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && brst_valid)); // R5
    AST_DONE_XOR_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && underrun)); // R10
    AST_UNDER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> eot); // R10
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!brst_valid && !mem_rd_req && !want_ready)); // R11
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brst_valid && !brst_ready && !cancel && !start) |=>
        (brst_valid && $stable(brst_addr) && $stable(brst_len))); // R12
endmodule

bind prd_walker prd_walker_chk #(.AW(AW), .LIM_BYTES(LIM_BYTES)) u_prd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cancel      (cancel),
    .tbl_base    (tbl_base),
    .want_ready  (want_ready),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .brst_valid  (brst_valid),
    .brst_ready  (brst_ready),
    .brst_addr   (brst_addr),
    .brst_len    (brst_len),
    .done        (done),
    .eot         (eot),
    .underrun    (underrun)
);

// File: tb/test_prd_walker.sv
// Bench: sweeps table lengths 1..8 with end marker plus one unmarked table,
// both directions, with and without burst backpressure, against an
// arithmetic model of the walk.
module test_prd_walker;
    localparam int AW  = 32;
    localparam int WLW = 20;
    localparam int LIM = 64;
    localparam int RLW = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cancel = 1'b0;
    logic [AW-1:0] tbl_base = '0;
    logic dir_wr = 1'b0;
    logic want_ready;
    logic want_valid = 1'b0;
    logic [WLW-1:0] want_len = '0;
    logic mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic brst_valid;
    logic brst_ready = 1'b1;
    logic [AW-1:0] brst_addr;
    logic [RLW-1:0] brst_len;
    logic brst_write;
    logic done, eot, underrun;

    prd_walker #(.AW(AW), .WLW(WLW), .LIM_BYTES(LIM)) i_prd_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
        .tbl_base(tbl_base), .dir_wr(dir_wr), .want_ready(want_ready),
        .want_valid(want_valid), .want_len(want_len),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .brst_valid(brst_valid), .brst_ready(brst_ready),
        .brst_addr(brst_addr), .brst_len(brst_len), .brst_write(brst_write),
        .done(done), .eot(eot), .underrun(underrun)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_done = 0, n_eot = 0, n_under = 0;
    bit bp_mode = 0;
    bit stall_all = 0;
    logic [63:0] dmem [0:15];
    logic [AW-1:0] cur_base = '0;
    logic [49:0] obs_b[$];
    logic [49:0] exp_b[$];
    logic [AW-1:0] obs_f[$];
    logic [AW-1:0] exp_f[$];

    // model state
    logic [AW-1:0] m_addr;
    int m_rem, m_ofs;
    bit m_last, m_ended, m_dir;
    bit e_done, e_under, e_eot;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Memory responder, burst sink and pulse counters, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        brst_ready = stall_all ? 1'b0 : (bp_mode ? ((cyc % 3) != 0) : 1'b1);
        mem_rd_valid = mem_rd_req;
        if (mem_rd_req) begin
            mem_rd_data = dmem[((mem_rd_addr - cur_base) >> 3) & 15];
            obs_f.push_back(mem_rd_addr);
        end
        if (brst_valid && brst_ready) obs_b.push_back({brst_write, brst_addr, brst_len});
        if (done) n_done++;
        if (eot) n_eot++;
        if (underrun) n_under++;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference for one request, from the requirements (R3..R10).
    task automatic model_req(input int w);
        int c;
        logic [63:0] d;
        e_done = 0; e_under = 0; e_eot = 0;
        while (w > 0) begin
            if (m_rem == 0) begin
                if (m_last || m_ofs >= LIM) begin
                    e_under = 1; e_eot = 1; m_ended = 1;
                    return;
                end
                exp_f.push_back(cur_base + AW'(m_ofs));
                d = dmem[m_ofs / 8];
                m_addr = d[31:0];
                m_rem = int'(d[47:32]) & 32'hFFFE;
                if (m_rem == 0) m_rem = 65536;
                m_last = d[63];
                m_ofs += 8;
            end
            c = (w < m_rem) ? w : m_rem;
            exp_b.push_back({m_dir, m_addr, RLW'(c)});
            m_addr += AW'(c);
            m_rem -= c;
            w -= c;
        end
        e_done = 1;
        if (m_rem == 0 && (m_last || m_ofs >= LIM)) begin
            e_eot = 1; m_ended = 1;
        end
    endtask

    task automatic begin_walk(input logic [AW-1:0] base, input bit dir);
        @(negedge clk);
        start = 1'b1; tbl_base = base; dir_wr = dir;
        @(negedge clk);
        start = 1'b0;
        cur_base = base;
        m_addr = '0; m_rem = 0; m_ofs = 0; m_last = 0; m_ended = 0; m_dir = dir;
        chk(want_ready == 1'b1, "R2", "ready after start", want_ready, 1);
    endtask

    task automatic do_req(input int w);
        int d0, u0, t0;
        obs_b.delete(); obs_f.delete(); exp_b.delete(); exp_f.delete();
        d0 = n_done; u0 = n_under; t0 = n_eot;
        model_req(w);
        chk(want_ready == 1'b1, "R7", "ready before request", want_ready, 1);
        want_valid = 1'b1; want_len = WLW'(w);
        @(negedge clk);
        want_valid = 1'b0;
        while (n_done == d0 && n_under == u0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(obs_f.size() == exp_f.size(), "R5", "fetch count", obs_f.size(), exp_f.size());
        foreach (exp_f[i])
            if (i < obs_f.size())
                chk(obs_f[i] == exp_f[i], "R5", "fetch address", obs_f[i], exp_f[i]);
        chk(obs_b.size() == exp_b.size(), "R6", "burst count", obs_b.size(), exp_b.size());
        foreach (exp_b[i])
            if (i < obs_b.size())
                chk(obs_b[i] == exp_b[i], "R3/R4/R6", "burst {dir,addr,len}", obs_b[i], exp_b[i]);
        chk((n_done - d0) == int'(e_done), "R10", "done pulses", n_done - d0, e_done);
        chk((n_under - u0) == int'(e_under), "R10", "underrun pulses", n_under - u0, e_under);
        chk((n_eot - t0) == int'(e_eot), "R8", "eot pulses", n_eot - t0, e_eot);
    endtask

    task automatic fill_table(input int nd, input bit has_last, input int v);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] lo;
            logic [14:0] junk;
            lo = 16'(((i * 58 + v * 26 + 2) % 200) + (i % 2));
            if ((v % 3) == 0 && i == 1) lo = 16'h0001;
            junk = 15'((i * 32'h1357 + v) & 32'h7FFF);
            dmem[i] = {(has_last && i == nd - 1), junk, lo,
                       32'h1000_0000 + 32'(i) * 32'h10000 + 32'(v) * 4};
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!want_ready && !mem_rd_req && !brst_valid && !done && !eot && !underrun,
            "R1", "idle after reset", {want_ready, mem_rd_req, brst_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!want_ready && !brst_valid, "R1", "idle out of reset", want_ready, 0);

        // Sweep: tables 1..8 with marker (R8), 9 = no marker (R9 fail-safe).
        for (int nd = 1; nd <= 9; nd++) begin
            for (int dir = 0; dir < 2; dir++) begin
                int v;
                v = nd * 2 + dir;
                bp_mode = (dir == 1);
                fill_table(nd, nd <= 8, v);
                begin_walk(32'h4000_0000 + 32'(v) * 32'h200, dir[0]);
                for (int k = 0; k < 8 && !m_ended; k++) begin
                    int w;
                    w = ((k * 83 + v * 29) % 300) + 1;
                    if ((v % 3) == 0 && k == 1) w = 70000;
                    do_req(w);
                end
                chk(want_ready == m_ended ? 1'b0 : 1'b1, nd <= 8 ? "R8" : "R9",
                    "walk state after requests", want_ready, !m_ended);
            end
        end
        bp_mode = 0;

        // R13: zero-length request ignored.
        fill_table(4, 1, 7);
        begin_walk(32'h5000_0000, 1'b0);
        begin
            int d0;
            d0 = n_done;
            obs_f.delete(); obs_b.delete();
            want_valid = 1'b1; want_len = '0;
            @(negedge clk);
            want_valid = 1'b0;
            repeat (5) @(negedge clk);
            chk(obs_f.size() == 0 && obs_b.size() == 0, "R13", "activity on zero request",
                obs_f.size() + obs_b.size(), 0);
            chk(want_ready == 1'b1, "R13", "still ready", want_ready, 1);
            chk(n_done == d0, "R13", "no done", n_done - d0, 0);
            do_req(10);
        end

        // R11/R12: cancel while a burst is stalled.
        fill_table(4, 1, 8);
        begin_walk(32'h6000_0000, 1'b1);
        stall_all = 1;
        obs_b.delete();
        want_valid = 1'b1; want_len = WLW'(50);
        @(negedge clk);
        want_valid = 1'b0;
        while (!brst_valid) @(negedge clk);
        begin
            logic [AW-1:0] a0;
            logic [RLW-1:0] l0;
            a0 = brst_addr; l0 = brst_len;
            @(negedge clk);
            chk(brst_valid && brst_addr == a0 && brst_len == l0, "R12", "burst held",
                {brst_valid, brst_addr}, {1'b1, a0});
        end
        cancel = 1'b1;
        @(negedge clk);
        cancel = 1'b0;
        chk(!brst_valid && !want_ready && !mem_rd_req, "R11", "quiet after cancel",
            {brst_valid, want_ready, mem_rd_req}, 0);
        stall_all = 0;
        repeat (4) @(negedge clk);
        chk(obs_b.size() == 0, "R11", "bursts after cancel", obs_b.size(), 0);
        begin_walk(32'h6000_0000, 1'b1);
        do_req(20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule